// File: doc/BRIEF.md
# External FIFO Bus Access Sequencer

This block turns single read or write requests from on-chip logic into strobed cycles on a parallel bus that faces an external FIFO device. A requester raises `req_valid` with a direction flag and a data word. The sequencer runs the cycle on the bus and answers with a one-clock `req_ack`. For a read, the returned word is presented on `rsp_rdata` in that same clock.

The external device reports its state on two status lines, full and empty. Each line passes through a two-flop synchronizer. When a line's gate is enabled, it holds off the kind of cycle it concerns: full holds off writes and empty holds off reads. A programmable limit, counted in clocks, bounds each hold-off. When the limit runs out, the cycle goes ahead anyway and a sticky timeout flag is set. A limit of zero removes the bound. The write strobe and the read strobe each have their own polarity. A polarity is captured when a cycle starts, so a change only takes effect between cycles.

One 32-bit configuration word holds the settings and can be read back. The `wide_mode` strap selects the reset value of the wait limit.

Top module: `xfifo_seq`

## Requirements
- R1: With the full gate (config bit 0) set and synchronized `ext_full` high, a write cycle gives no strobe. With the gate clear, `ext_full` has no effect and a write acks on the 3rd clock after `req_valid` is taken.
- R2: With the empty gate (config bit 1) set and synchronized `ext_empty` high, a read cycle gives no strobe. With the gate clear, `ext_empty` has no effect.
- R3: Write polarity (config bit 2): 1 means active low and 0 means active high. Each write gives exactly one active clock on `bus_wr_stb`, with `req_wdata` on `bus_dout` during that clock, and no read strobe.
- R4: Read polarity (config bit 3): 1 means active low and 0 means active high. Each read gives exactly one active clock on `bus_rd_stb` and no write strobe. `bus_din` from that clock appears on `rsp_rdata` with the ack.
- R5: Both strobes sit at their inactive level in reset and whenever no cycle is running. A polarity written during a cycle does not alter that cycle.
- R6: The wait limit is config bits 11:4. With limit N > 0 and a stall that persists, the cycle proceeds after N stalled clocks, so the ack comes 3+N clocks after the request. The timeout flag, bit 12, is then set. It stays set until a config write with bit 12 = 1 clears it.
- R7: With limit 0, a stalled cycle waits indefinitely and sets no timeout flag.
- R8: The wait limit resets to 0xFF when `wide_mode` is high during reset, and to 0x00 otherwise. All other fields reset to 0.
- R9: A status change reaches the stall logic only after the two-flop synchronizer. When full falls, the ack follows 4 clocks later.
- R10: Config bits 31:13 read as zero and ignore writes.
- R11: `req_ack` is a single-clock pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | Strap that selects the wait-limit reset value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback, including the timeout flag |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with `req_ack` |
| ext_full | input | 1 | External full status (asynchronous) |
| ext_empty | input | 1 | External empty status (asynchronous) |
| bus_wr_stb | output | 1 | Write strobe, programmable polarity |
| bus_rd_stb | output | 1 | Read strobe, programmable polarity |
| bus_dout | output | DATA_W | Data driven toward the device |
| bus_din | input | DATA_W | Data returned by the device |

## Verification
The assertions check on every clock:
- the ack is a single pulse;
- a strobe lasts exactly one clock;
- a stall that has not expired blocks the strobe;
- the latched polarity stays frozen while a cycle runs;
- the wait counter never passes its limit;
- an expired count holds;
- the timeout flag is sticky and clears on command.

Only the bench scenarios can show the following:
- exact ack latencies against the limit;
- strobe levels under every polarity pair;
- gating under every enable and status combination;
- the synchronizer delay;
- the strap-dependent reset value;
- the zero readback of the reserved bits.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  localparam int WAIT_W = 8;
  localparam int REG_W  = 32;
  localparam int B_FULL_EN  = 0;
  localparam int B_EMPTY_EN = 1;
  localparam int B_WR_LOW   = 2;
  localparam int B_RD_LOW   = 3;
  localparam int B_MW_LO    = 4;
  localparam int B_TO       = B_MW_LO + WAIT_W;

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_STRB, ST_ACK} seq_state_e;

  typedef struct packed {
    logic              full_en;
    logic              empty_en;
    logic              wr_low;
    logic              rd_low;
    logic [WAIT_W-1:0] max_wait;
  } xfs_cfg_t;

  // Level driven on a strobe pin: active ^ active-low-select.
  function automatic logic drive_level(input logic active, input logic act_low);
    return active ^ act_low;
  endfunction

  // A nonzero limit is reached when the counted stall clocks equal it.
  function automatic logic limit_hit(input logic [WAIT_W-1:0] cnt,
                                     input logic [WAIT_W-1:0] lim);
    return (lim != '0) && (cnt == lim);
  endfunction

  function automatic logic [REG_W-1:0] pack_cfg(input xfs_cfg_t c, input logic to);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_FULL_EN]             = c.full_en;
    r[B_EMPTY_EN]            = c.empty_en;
    r[B_WR_LOW]              = c.wr_low;
    r[B_RD_LOW]              = c.rd_low;
    r[B_MW_LO +: WAIT_W]     = c.max_wait;
    r[B_TO]                  = to;
    return r;
  endfunction
endpackage

// File: rtl/xfs_sync.sv
module xfs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfs_cfg.sv
module xfs_cfg
  import xfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             to_set,
  output logic [REG_W-1:0] rd_data,
  output xfs_cfg_t         cfg,
  output logic             to_flag
);
  xfs_cfg_t cfg_q;
  logic     to_q;
  logic     clr_req;
  logic     unused_hi;

  assign clr_req   = wr_en && wr_data[B_TO];
  assign unused_hi = ^wr_data[REG_W-1:B_TO+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.full_en  <= 1'b0;
      cfg_q.empty_en <= 1'b0;
      cfg_q.wr_low   <= 1'b0;
      cfg_q.rd_low   <= 1'b0;
      cfg_q.max_wait <= wide_mode ? '1 : '0;
    end else if (wr_en) begin
      cfg_q.full_en  <= wr_data[B_FULL_EN];
      cfg_q.empty_en <= wr_data[B_EMPTY_EN];
      cfg_q.wr_low   <= wr_data[B_WR_LOW];
      cfg_q.rd_low   <= wr_data[B_RD_LOW];
      cfg_q.max_wait <= wr_data[B_MW_LO +: WAIT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       to_q <= 1'b0;
    else if (to_set)  to_q <= 1'b1;
    else if (clr_req) to_q <= 1'b0;
  end

  assign cfg     = cfg_q;
  assign to_flag = to_q;
  assign rd_data = pack_cfg(cfg_q, to_q);

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !clr_req) |=> to_flag); // R6
  AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !to_set) |=> !to_flag); // R6
endmodule

// File: rtl/xfs_wait.sv
module xfs_wait #(
  parameter int W = xfs_pkg::WAIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  input  logic         tick,
  output logic         expired
);
  import xfs_pkg::*;
  logic [W-1:0] cnt, lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= '0;
    end else if (load) begin
      cnt   <= '0;
      lim_q <= limit;
    end else if (tick && !expired && (cnt != '1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = limit_hit(cnt, lim_q);

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q != '0) |-> (cnt <= lim_q)); // R6
  AST_EXPIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R6
endmodule

// File: rtl/xfifo_seq.sv
module xfifo_seq
  import xfs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ext_full,
  input  logic              ext_empty,
  output logic              bus_wr_stb,
  output logic              bus_rd_stb,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  xfs_cfg_t          cfg;
  logic              to_flag;
  logic [1:0]        stat_s;
  logic              full_s, empty_s;
  seq_state_e        state_q, state_d;
  logic              wr_q, pol_wr_q, pol_rd_q;
  logic [DATA_W-1:0] data_q, rdata_q;

  // Named internal events used by logic and assertions
  logic start_evt, in_hold, in_idle, stall_now, wait_exp, timeout_evt, strobe_on;

  xfs_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .wr_en(cfg_we), .wr_data(cfg_wdata), .to_set(timeout_evt),
    .rd_data(cfg_rdata), .cfg(cfg), .to_flag(to_flag)
  );

  xfs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_empty, ext_full}), .q(stat_s)
  );
  assign full_s  = stat_s[0];
  assign empty_s = stat_s[1];

  assign in_idle     = (state_q == ST_IDLE);
  assign in_hold     = (state_q == ST_HOLD);
  assign strobe_on   = (state_q == ST_STRB);
  assign start_evt   = in_idle && req_valid;
  assign stall_now   = in_hold && (wr_q ? (cfg.full_en && full_s)
                                        : (cfg.empty_en && empty_s));
  assign timeout_evt = stall_now && wait_exp;

  xfs_wait #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .limit(cfg.max_wait),
    .tick(stall_now), .expired(wait_exp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_HOLD;
      ST_HOLD: if (!stall_now || wait_exp) state_d = ST_STRB;
      ST_STRB: state_d = ST_ACK;
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      pol_wr_q <= 1'b0;
      pol_rd_q <= 1'b0;
      data_q   <= '0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_evt) begin
        wr_q     <= req_write;
        data_q   <= req_wdata;
        pol_wr_q <= cfg.wr_low;
        pol_rd_q <= cfg.rd_low;
      end
      if (strobe_on && !wr_q) rdata_q <= bus_din;
    end
  end

  assign bus_wr_stb = drive_level(strobe_on && wr_q,  in_idle ? cfg.wr_low : pol_wr_q);
  assign bus_rd_stb = drive_level(strobe_on && !wr_q, in_idle ? cfg.rd_low : pol_rd_q);
  assign bus_dout   = data_q;
  assign req_ack    = (state_q == ST_ACK);
  assign rsp_rdata  = rdata_q;

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R11
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |=> !strobe_on); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_now && !wait_exp) |=> !strobe_on); // R1
  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle) |=> ($stable(pol_wr_q) && $stable(pol_rd_q))); // R5
endmodule

// File: tb/xfifo_seq_bench.sv
module xfifo_seq_bench;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, bus_dout, bus_din = '0;
  logic req_ack, ext_full = 1'b0, ext_empty = 1'b0, bus_wr_stb, bus_rd_stb;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic exp_wl = 0, exp_rl = 0;

  always #5 clk = ~clk;

  xfifo_seq #(.DATA_W(DW)) u_xfifo_seq (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .ext_full(ext_full), .ext_empty(ext_empty),
    .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input bit fe, input bit ee, input bit wl,
                                           input bit rl, input int mw, input bit clr);
    return {19'd0, clr, 8'(mw), rl, wl, ee, fe};
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [DW-1:0] d, input logic [DW-1:0] din,
                        output int lat, output int nwr, output int nrd,
                        output logic [DW-1:0] seen, output logic [DW-1:0] rdv);
    bit done = 0;
    bus_din = din; lat = 0; nwr = 0; nrd = 0; seen = '0; rdv = '0;
    @(negedge clk); req_valid = 1'b1; req_write = wr; req_wdata = d;
    while (!done && lat < 2000) begin
      @(negedge clk); lat++;
      if (bus_wr_stb == !exp_wl) begin nwr++; seen = bus_dout; end
      if (bus_rd_stb == !exp_rl) nrd++;
      if (req_ack) begin done = 1; rdv = rsp_rdata; end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack, "R11 ack single pulse", req_ack, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, nwr, nrd, cnt_bad, act1;
    logic [DW-1:0] seen, rdv, d;
    bit stall;

    // R8 strap high
    wide_mode = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_wr_stb == 0 && bus_rd_stb == 0, "R5 strobes inactive in reset", {bus_wr_stb, bus_rd_stb}, 0);
    rst_n = 1'b1; @(negedge clk);
    chk(cfg_rdata == 32'h0000_0FF0, "R8 wide reset value", cfg_rdata, 32'h0FF0);
    chk(!req_ack, "R11 no ack after reset", req_ack, 0);
    // R8 strap low
    rst_n = 1'b0; wide_mode = 1'b0; repeat (2) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    chk(cfg_rdata == 32'h0, "R8 narrow reset value", cfg_rdata, 0);

    // R10 reserved bits
    cfg_write(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0000_0FFF, "R10 reserved read zero", cfg_rdata, 32'h0FFF);
    exp_wl = 1; exp_rl = 1;

    // Sweep enables, polarities, status levels, direction (limit 3)
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++) begin
          exp_wl = c[2]; exp_rl = c[3];
          cfg_write(cfg_word(c[0], c[1], c[2], c[3], 3, 1));
          ext_full = s[0]; ext_empty = s[1];
          repeat (3) @(negedge clk);
          chk(bus_wr_stb == exp_wl && bus_rd_stb == exp_rl, "R5 idle level",
              {bus_wr_stb, bus_rd_stb}, {exp_wl, exp_rl});
          d = 16'(c * 37 + s * 5 + w + 16'h1200);
          access(w[0], d, ~d, lat, nwr, nrd, seen, rdv);
          stall = w[0] ? (c[0] && s[0]) : (c[1] && s[1]);
          if (w[0]) begin
            chk(lat == 3 + (stall ? 3 : 0), "R1 write latency", lat, 3 + (stall ? 3 : 0));
            chk(nwr == 1 && nrd == 0, "R3 one write strobe", nwr * 16 + nrd, 16);
            chk(seen == d, "R3 write data", seen, d);
          end else begin
            chk(lat == 3 + (stall ? 3 : 0), "R2 read latency", lat, 3 + (stall ? 3 : 0));
            chk(nrd == 1 && nwr == 0, "R4 one read strobe", nrd * 16 + nwr, 16);
            chk(rdv == ~d, "R4 read data", rdv, ~d);
          end
          chk(cfg_rdata[12] == stall, "R6 timeout flag", cfg_rdata[12], stall);
        end

    // R6 limit sweep
    exp_wl = 0; exp_rl = 0;
    for (int n = 1; n <= 6; n++) begin
      cfg_write(cfg_word(1, 0, 0, 0, n, 1));
      ext_full = 1'b1; ext_empty = 1'b0;
      repeat (3) @(negedge clk);
      access(1'b1, 16'hA5A5, 16'h0, lat, nwr, nrd, seen, rdv);
      chk(lat == 3 + n, "R6 bounded wait latency", lat, 3 + n);
      chk(cfg_rdata[12] == 1, "R6 timeout set", cfg_rdata[12], 1);
      cfg_write(cfg_word(1, 0, 0, 0, n, 0));
      chk(cfg_rdata[12] == 1, "R6 timeout sticky", cfg_rdata[12], 1);
      cfg_write(cfg_word(1, 0, 0, 0, n, 1));
      chk(cfg_rdata[12] == 0, "R6 timeout cleared", cfg_rdata[12], 0);
    end

    // R7 unbounded wait, R9 synchronizer delay
    cfg_write(cfg_word(1, 0, 0, 0, 0, 1));
    ext_full = 1'b1; repeat (3) @(negedge clk);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_wdata = 16'h3C3C;
    cnt_bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (req_ack || bus_wr_stb) cnt_bad++;
    end
    chk(cnt_bad == 0, "R7 held while full", cnt_bad, 0);
    ext_full = 1'b0; lat = 0;
    while (!req_ack && lat < 100) begin @(negedge clk); lat++; end
    req_valid = 1'b0;
    chk(lat == 4, "R9 sync delay to ack", lat, 4);
    chk(cfg_rdata[12] == 0, "R7 no timeout flag", cfg_rdata[12], 0);

    // R5 polarity change mid-cycle
    cfg_write(cfg_word(1, 0, 0, 0, 0, 1));
    ext_full = 1'b1; repeat (3) @(negedge clk);
    @(negedge clk); req_valid = 1'b1; req_write = 1'b1; req_wdata = 16'h0F0F;
    repeat (4) @(negedge clk);
    cfg_write(cfg_word(1, 0, 1, 0, 0, 0));
    chk(bus_wr_stb == 0, "R5 old inactive level kept", bus_wr_stb, 0);
    ext_full = 1'b0; act1 = 0; lat = 0;
    while (!req_ack && lat < 100) begin
      @(negedge clk); lat++;
      if (bus_wr_stb) act1++;
    end
    req_valid = 1'b0;
    chk(act1 == 1, "R5 cycle keeps old polarity", act1, 1);
    @(negedge clk);
    chk(bus_wr_stb == 1, "R5 new idle level", bus_wr_stb, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule